// File: doc/BRIEF.md
# Receive Byte Counter with Early Warning

This block follows one incoming frame at a time and keeps a running count of its bytes. A frame opens with a start pulse and closes with an end pulse. Every byte strobe seen while the frame is open adds one to the count. When the frame closes, the block reports a frame that is too short unless short frames have been allowed by configuration.

While the frame is being received, the block compares the count with a programmable threshold. An 8-bit threshold value is multiplied by sixteen, so the threshold covers 0 to 4080 bytes in 16-byte steps. When the count reaches the threshold, a sticky warning status bit is set. Software clears it with a write-one-to-clear pulse. A per-source mask gates the status bit onto the interrupt request line. The warning fires only once per arming. It is armed again by the start of the next frame or by a new write to the threshold register. Because of this, a threshold written below the count of a frame in progress raises the warning straight away.

Byte strobes carry no data and apply no back-pressure: the block accepts every strobe in the cycle it arrives, so it has no ready output. All other pins are plain level or pulse controls.

Top module: `rx_bytecount_warn`

## Requirements
- R1: `frame_start` loads the count with 0, or with 1 if `byte_valid` is high in the same cycle. While a frame is open, each `byte_valid` cycle adds one. At all other times the count holds, including byte strobes that arrive after `frame_end`. A frame is open from the edge after `frame_start` until the edge after `frame_end`.
- R2: The count saturates at 4095 and does not wrap.
- R3: At the edge that samples `frame_end` for an open frame, `runt_reject` rises for exactly one cycle if the final count is below 64. The final count includes a byte strobe in the end cycle. This happens only when `accept_runt` is 0.
- R4: With `accept_runt` at 1, `runt_reject` stays low for any frame length.
- R5: `thr_write` loads `thr_value`, and the threshold is that value times 16. `warn_status` is set on the edge after the one at which the count first becomes greater than or equal to the threshold, provided the frame is open and the warning is armed.
- R6: `warn_status` is never set while no frame is open, whatever the threshold.
- R7: A high `irq_clear` clears `warn_status` at the next edge.
- R8: After the warning fires, it does not fire again in the same frame. It is armed again by `frame_start` or `thr_write`. A write of a threshold at or below the current count of an open frame sets `warn_status` two edges after the write.
- R9: `warn_irq` is high exactly when `warn_status` and `irq_mask` are both high.
- R10: If a set and `irq_clear` happen in the same cycle, `warn_status` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Pulse opening a frame |
| frame_end | input | 1 | Pulse closing the open frame |
| byte_valid | input | 1 | One received byte this cycle |
| accept_runt | input | 1 | Allow frames shorter than 64 bytes |
| thr_value | input | 8 | Threshold in units of 16 bytes |
| thr_write | input | 1 | Load `thr_value` and re-arm |
| irq_clear | input | 1 | Write-one-to-clear of the warning status |
| irq_mask | input | 1 | Enable of the warning interrupt |
| byte_count | output | 12 | Byte count of the current or last frame |
| runt_reject | output | 1 | One-cycle pulse: frame rejected as too short |
| warn_status | output | 1 | Sticky early-warning status |
| warn_irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default parameters: a 12-bit count, an 8-bit threshold scaled by 16, and a 64-byte minimum frame. These defaults bring the top threshold of 4080 and the saturation point of 4095 within reach of a single long frame. One frame crosses both the largest threshold and the saturation point. Other frames cover the runt boundary from both sides, re-arming by a threshold write in the middle of a frame, and a set colliding with a clear.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int unsigned RBC_CNT_W     = 12;
  localparam int unsigned RBC_THR_W     = 8;
  localparam int unsigned RBC_THR_SHIFT = 4;
  localparam int unsigned RBC_MIN_FRAME = 64;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_SPENT = 2'd2
  } warn_arm_e;
endpackage

// File: rtl/rbc_counter.sv
module rbc_counter #(
  parameter int unsigned CNT_W     = rbc_pkg::RBC_CNT_W,
  parameter int unsigned MIN_FRAME = rbc_pkg::RBC_MIN_FRAME
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             byte_valid,
  input  logic             accept_runt,
  output logic [CNT_W-1:0] count_q,
  output logic             open_q,
  output logic             runt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_FRAME);

  logic [CNT_W-1:0] count_d;
  logic             at_max;
  logic             short_frame;

  assign at_max = (count_q == CNT_MAX);

  always_comb begin
    count_d = count_q;
    if (frame_start)
      count_d = byte_valid ? CNT_W'(1) : '0;
    else if (open_q && byte_valid && !at_max)
      count_d = count_q + CNT_W'(1);
  end

  assign short_frame = (count_d < CNT_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      open_q  <= 1'b0;
      runt_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      runt_q  <= frame_end && open_q && !frame_start && short_frame && !accept_runt;
      if (frame_start)
        open_q <= 1'b1;
      else if (frame_end)
        open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rbc_warn.sv
module rbc_warn #(
  parameter int unsigned CNT_W     = rbc_pkg::RBC_CNT_W,
  parameter int unsigned THR_W     = rbc_pkg::RBC_THR_W,
  parameter int unsigned THR_SHIFT = rbc_pkg::RBC_THR_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             open_q,
  input  logic [CNT_W-1:0] count_q,
  input  logic [THR_W-1:0] thr_value,
  input  logic             thr_write,
  input  logic             irq_clear,
  output logic             status_q
);
  import rbc_pkg::*;

  localparam int unsigned SCL_W = THR_W + THR_SHIFT;
  localparam int unsigned CMP_W = (SCL_W > CNT_W) ? SCL_W : CNT_W;

  logic [THR_W-1:0] thr_q;
  logic [SCL_W-1:0] thr_scaled;
  warn_arm_e        arm_q;
  logic             reached;
  logic             fire;

  generate
    if (THR_SHIFT == 0) begin : g_noshift
      assign thr_scaled = thr_q;
    end else begin : g_shift
      assign thr_scaled = {thr_q, {THR_SHIFT{1'b0}}};
    end
  endgenerate

  assign reached = CMP_W'(count_q) >= CMP_W'(thr_scaled);
  assign fire    = open_q && (arm_q == WS_ARMED) && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q    <= '0;
      arm_q    <= WS_IDLE;
      status_q <= 1'b0;
    end else begin
      if (thr_write)
        thr_q <= thr_value;

      if (frame_start || thr_write)
        arm_q <= WS_ARMED;
      else if (fire)
        arm_q <= WS_SPENT;

      if (fire)
        status_q <= 1'b1;
      else if (irq_clear)
        status_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_bytecount_warn.sv
module rx_bytecount_warn #(
  parameter int unsigned CNT_W     = rbc_pkg::RBC_CNT_W,
  parameter int unsigned THR_W     = rbc_pkg::RBC_THR_W,
  parameter int unsigned THR_SHIFT = rbc_pkg::RBC_THR_SHIFT,
  parameter int unsigned MIN_FRAME = rbc_pkg::RBC_MIN_FRAME
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             byte_valid,
  input  logic             accept_runt,
  input  logic [THR_W-1:0] thr_value,
  input  logic             thr_write,
  input  logic             irq_clear,
  input  logic             irq_mask,
  output logic [CNT_W-1:0] byte_count,
  output logic             runt_reject,
  output logic             warn_status,
  output logic             warn_irq
);
  logic [CNT_W-1:0] cnt;
  logic             frame_open;

  rbc_counter #(.CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .byte_valid  (byte_valid),
    .accept_runt (accept_runt),
    .count_q     (cnt),
    .open_q      (frame_open),
    .runt_q      (runt_reject)
  );

  rbc_warn #(.CNT_W(CNT_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)) u_warn (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .open_q      (frame_open),
    .count_q     (cnt),
    .thr_value   (thr_value),
    .thr_write   (thr_write),
    .irq_clear   (irq_clear),
    .status_q    (warn_status)
  );

  assign byte_count = cnt;
  assign warn_irq   = warn_status & irq_mask;
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
  parameter int unsigned CNT_W = rbc_pkg::RBC_CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             frame_end,
  input logic             byte_valid,
  input logic             accept_runt,
  input logic             irq_clear,
  input logic             irq_mask,
  input logic [CNT_W-1:0] byte_count,
  input logic             runt_reject,
  input logic             warn_status,
  input logic             warn_irq
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic shadow_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shadow_open <= 1'b0;
    else if (frame_start) shadow_open <= 1'b1;
    else if (frame_end)   shadow_open <= 1'b0;
  end

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !byte_valid |=> byte_count == '0); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start && !byte_valid |=> $stable(byte_count)); // R1
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count == TOP && !frame_start |=> byte_count == TOP); // R2
  AST_RUNT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    runt_reject |-> $past(frame_end)); // R3
  AST_RUNT_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    runt_reject |-> !$past(accept_runt)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_status) |-> $past(shadow_open)); // R6
  AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_status) |-> $past(irq_clear)); // R7
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !warn_irq); // R9
endmodule

bind rx_bytecount_warn rbc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .frame_end   (frame_end),
  .byte_valid  (byte_valid),
  .accept_runt (accept_runt),
  .irq_clear   (irq_clear),
  .irq_mask    (irq_mask),
  .byte_count  (byte_count),
  .runt_reject (runt_reject),
  .warn_status (warn_status),
  .warn_irq    (warn_irq)
);

// File: tb/rx_bytecount_warn_test.sv
`timescale 1ns/1ps
module rx_bytecount_warn_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 0, frame_end = 0, byte_valid = 0, accept_runt = 0;
  logic [7:0]  thr_value = 0;
  logic        thr_write = 0, irq_clear = 0, irq_mask = 0;
  logic [11:0] byte_count;
  logic        runt_reject, warn_status, warn_irq;

  always #2 clk = ~clk;

  rx_bytecount_warn uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .byte_valid(byte_valid), .accept_runt(accept_runt), .thr_value(thr_value),
    .thr_write(thr_write), .irq_clear(irq_clear), .irq_mask(irq_mask),
    .byte_count(byte_count), .runt_reject(runt_reject),
    .warn_status(warn_status), .warn_irq(warn_irq)
  );

  typedef struct {
    int    cyc;
    int    sel;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    pc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;

  always @(posedge clk) pc <= pc + 1;

  function automatic int probe(int sel);
    case (sel)
      0: return int'(byte_count);
      1: return int'(runt_reject);
      2: return int'(warn_status);
      default: return int'(warn_irq);
    endcase
  endfunction

  // monitor: pops the items due this cycle and compares them
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == pc) begin
        n_run++;
        if (probe(q[i].sel) != q[i].exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", q[i].tag,
                   q[i].sel, probe(q[i].sel), q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_now(int sel, int exp, string tag);
    item_t it;
    it.cyc = pc; it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(bit fs, bit fe, bit bv);
    frame_start = fs; frame_end = fe; byte_valid = bv;
    @(posedge clk); #1;
    frame_start = 0; frame_end = 0; byte_valid = 0;
    thr_write = 0; irq_clear = 0;
  endtask

  task automatic bytes(int n);
    for (int i = 0; i < n; i++) step(0, 0, 1);
  endtask

  task automatic write_thr(logic [7:0] v);
    thr_value = v; thr_write = 1; step(0, 0, 0);
  endtask

  task automatic clear_step();
    irq_clear = 1; step(0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(0, 0, 0);
    expect_now(0, 0, "R1 reset count");
    expect_now(1, 0, "R3 reset runt");
    expect_now(2, 0, "R6 reset status");
    expect_now(3, 0, "R9 reset irq");

    // frame A: threshold 64 bytes
    irq_mask = 1;
    write_thr(8'd4);
    step(1, 0, 0);
    expect_now(0, 0, "R1 start zero");
    bytes(63);
    expect_now(0, 63, "R1 count 63");
    expect_now(2, 0, "R5 below threshold");
    bytes(1);
    expect_now(0, 64, "R1 count 64");
    expect_now(2, 0, "R5 one edge latency");
    step(0, 0, 0);
    expect_now(2, 1, "R5 fires at 64");
    expect_now(3, 1, "R9 irq unmasked");
    step(0, 1, 0);
    expect_now(1, 0, "R3 64 bytes not runt");
    bytes(3);
    expect_now(0, 64, "R1 bytes after end ignored");
    clear_step();
    expect_now(2, 0, "R7 clear");

    // frame B: runt, byte on end cycle counted
    step(1, 0, 1);
    expect_now(0, 1, "R1 start with byte");
    bytes(9);
    step(0, 1, 1);
    expect_now(0, 11, "R1 end byte counted");
    expect_now(1, 1, "R3 runt pulse");
    step(0, 0, 0);
    expect_now(1, 0, "R3 pulse one cycle");

    // frame C: short frame accepted
    accept_runt = 1;
    step(1, 0, 0);
    bytes(5);
    step(0, 1, 0);
    expect_now(1, 0, "R4 runt accepted");
    accept_runt = 0;

    // frame B2: boundary 63 vs runt
    step(1, 0, 0);
    bytes(62);
    step(0, 1, 1);
    expect_now(0, 63, "R1 count 63 at end");
    expect_now(1, 1, "R3 63 is runt");

    // frame D: rearm rules
    irq_mask = 0;
    step(1, 0, 0);
    bytes(70);
    expect_now(2, 1, "R5 fired in frame D");
    expect_now(3, 0, "R9 masked");
    clear_step();
    expect_now(2, 0, "R7 clear in frame");
    bytes(10);
    expect_now(2, 0, "R8 no refire same frame");
    write_thr(8'd2);
    expect_now(2, 0, "R8 write latency");
    irq_mask = 1;
    step(0, 0, 0);
    expect_now(2, 1, "R8 write below count fires");
    expect_now(3, 1, "R9 irq on");
    clear_step();
    expect_now(2, 0, "R7 clear again");
    write_thr(8'd1);
    clear_step();
    expect_now(2, 1, "R10 set wins over clear");
    step(0, 1, 0);
    clear_step();

    // idle: no fire without an open frame
    write_thr(8'd0);
    step(0, 0, 0);
    step(0, 0, 0);
    expect_now(2, 0, "R6 idle no fire");
    step(1, 0, 0);
    step(0, 0, 0);
    expect_now(2, 1, "R6 fires once frame open");
    step(0, 1, 0);
    clear_step();

    // frame E: top threshold and saturation
    write_thr(8'd255);
    step(1, 0, 0);
    bytes(4080);
    expect_now(0, 4080, "R1 count 4080");
    expect_now(2, 0, "R5 top threshold latency");
    bytes(1);
    expect_now(2, 1, "R5 fires at 4080");
    bytes(19);
    expect_now(0, 4095, "R2 saturate");
    bytes(2);
    expect_now(0, 4095, "R2 held at max");
    step(0, 1, 0);
    step(0, 0, 0);
    step(0, 0, 0);

    if (q.size() != 0) begin
      n_fail += q.size();
      $display("FAIL %0d checks never evaluated", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule